// File: doc/BRIEF.md
# Scroll and Video Address Register Unit

This block holds the processor-visible scroll and video memory address state of a tile-based display engine. The processor writes bytes to two ports. The scroll port sets the horizontal and vertical scroll. The address port sets the video memory address. Both ports share one phase flag that chooses between the first and the second byte of a pair. Writes build up a 15-bit staging register and a 3-bit fine horizontal offset. The live 15-bit address register is loaded from the staging register in two cases: on the second address-port byte, or on a frame-start strobe.

Because the ports share the phase flag, software can mix writes to them. This lets it reload the scroll in the middle of a frame. The usual four-write split sequence is:

1. An address byte carrying the nametable bits.
2. A scroll byte, which lands in the vertical phase.
3. A scroll byte in the horizontal phase.
4. An address byte carrying the packed coarse values, which commits everything to the live register.

A status-read strobe sends the phase back to the first byte.

Top module: `scroll_addr_unit`

## Requirements
- R1: The phase flag (`second_phase`, 0 = first byte) inverts on every accepted write to either port, unless a status read happens in the same cycle.
- R2: With `port_sel`=0 (scroll port) in the first phase, data bits 7:3 go to staging bits 4:0 and data bits 2:0 go to `fine_x`. No other staging bit changes.
- R3: With the scroll port in the second phase, data bits 7:3 go to staging bits 9:5 and data bits 2:0 go to staging bits 14:12. `fine_x` and all other staging bits are kept.
- R4: With `port_sel`=1 (address port) in the first phase, data bits 5:0 go to staging bits 13:8 and staging bit 14 is cleared. Staging bits 7:0 are kept.
- R5: With the address port in the second phase, the data byte goes to staging bits 7:0. The whole resulting staging value appears on `cur_addr` after that clock edge.
- R6: Scroll-port writes and first-phase address writes leave `cur_addr` unchanged when no frame-start strobe is present.
- R7: `status_rd` forces the phase flag to 0 after the edge. This takes priority over the flip caused by a write in the same cycle. A write in that cycle still uses the phase held before the edge.
- R8: `frame_copy` loads the staging register into `cur_addr`. If a write happens in the same cycle, the copied value includes that write.
- R9: While `rst_n` is low, `cur_addr`, `fine_x`, `second_phase` and the staging register are all zero.
- R10: The split sequence address(nt<<2), scroll(Y), scroll(X), address(((Y>>3)&7)<<5 | X>>3) produces `cur_addr` = {Y[2:0], nt, Y[7:3], X[7:3]} and `fine_x` = X[2:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Processor byte write strobe |
| port_sel | input | 1 | 0 = scroll port, 1 = address port |
| wr_data | input | 8 | Write byte |
| status_rd | input | 1 | Status read strobe; clears the phase flag |
| frame_copy | input | 1 | Frame-start strobe; staging to live address |
| cur_addr | output | 15 | Live video memory address |
| fine_x | output | 3 | Fine horizontal scroll |
| second_phase | output | 1 | Phase flag, 1 = next byte is second |

## Verification
Every result is registered once. A write, status read or frame strobe presented before an edge shows on `cur_addr`, `fine_x` and `second_phase` right after that edge, with no further delay. The bench changes inputs and samples outputs 1 ns after each rising edge. A behavioural model is advanced on the same edge, and all outputs are compared with it every cycle. The staging register has no output of its own. Its effect is therefore seen through a later second address write or frame strobe, which moves it onto `cur_addr` one edge after being presented.

// File: rtl/sa_pkg.sv
package sa_pkg;
  localparam int ADDR_W  = 15;
  localparam int FINEX_W = 3;
  localparam int DATA_W  = 8;
  localparam int CRS_W   = 5;

  typedef enum logic {
    PORT_SCROLL = 1'b0,
    PORT_ADDR   = 1'b1
  } port_e;

  typedef logic [ADDR_W-1:0] vaddr_t;
endpackage

// File: rtl/sa_phase.sv
module sa_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic status_rd,
  output logic phase_q
);
  logic phase_d;
  logic phase_en;

  always_comb begin
    phase_en = wr_en | status_rd;
    phase_d  = status_rd ? 1'b0 : ~phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_q <= 1'b0;
    else if (phase_en) phase_q <= phase_d;
  end
endmodule

// File: rtl/sa_staging.sv
module sa_staging
  import sa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              port_sel,
  input  logic              phase,
  input  logic [DATA_W-1:0] wr_data,
  output vaddr_t            stage_q,
  output vaddr_t            stage_d,
  output logic [FINEX_W-1:0] fine_q
);
  logic [FINEX_W-1:0] fine_d;
  logic               stage_en;
  logic               fine_en;

  always_comb begin
    stage_d  = stage_q;
    fine_d   = fine_q;
    stage_en = wr_en;
    fine_en  = 1'b0;
    if (wr_en) begin
      if (port_e'(port_sel) == PORT_SCROLL) begin
        if (!phase) begin
          stage_d[CRS_W-1:0] = wr_data[DATA_W-1:FINEX_W];
          fine_d             = wr_data[FINEX_W-1:0];
          fine_en            = 1'b1;
        end else begin
          stage_d[2*CRS_W-1:CRS_W] = wr_data[DATA_W-1:FINEX_W];
          stage_d[ADDR_W-1:12]     = wr_data[FINEX_W-1:0];
        end
      end else begin
        if (!phase) begin
          stage_d[ADDR_W-1]    = 1'b0;
          stage_d[ADDR_W-2:8]  = wr_data[5:0];
        end else begin
          stage_d[DATA_W-1:0]  = wr_data;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stage_q <= '0;
    else if (stage_en) stage_q <= stage_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fine_q <= '0;
    else if (fine_en) fine_q <= fine_d;
  end
endmodule

// File: rtl/sa_live.sv
module sa_live
  import sa_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  vaddr_t stage_d,
  output vaddr_t live_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    live_q <= '0;
    else if (load) live_q <= stage_d;
  end
endmodule

// File: rtl/scroll_addr_unit.sv
module scroll_addr_unit
  import sa_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               port_sel,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               status_rd,
  input  logic               frame_copy,
  output logic [ADDR_W-1:0]  cur_addr,
  output logic [FINEX_W-1:0] fine_x,
  output logic               second_phase
);
  vaddr_t stage_q;
  vaddr_t stage_d;
  vaddr_t live_q;
  logic   commit;

  always_comb
    commit = frame_copy |
             (wr_en & (port_e'(port_sel) == PORT_ADDR) & second_phase);

  sa_phase u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .status_rd (status_rd),
    .phase_q   (second_phase)
  );

  sa_staging u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .port_sel (port_sel),
    .phase    (second_phase),
    .wr_data  (wr_data),
    .stage_q  (stage_q),
    .stage_d  (stage_d),
    .fine_q   (fine_x)
  );

  sa_live u_live (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (commit),
    .stage_d (stage_d),
    .live_q  (live_q)
  );

  assign cur_addr = live_q;
endmodule

// File: rtl/sa_checker.sv
module sa_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        port_sel,
  input logic [7:0]  wr_data,
  input logic        status_rd,
  input logic        frame_copy,
  input logic [14:0] cur_addr,
  input logic [2:0]  fine_x,
  input logic        second_phase
);
  AST_PHASE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !status_rd) |=> (second_phase != $past(second_phase))); // R1

  AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd |=> !second_phase); // R7

  AST_FINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !port_sel && !second_phase) |=> $stable(fine_x)); // R3

  AST_COMMIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && port_sel && second_phase) |=> (cur_addr[7:0] == $past(wr_data))); // R5

  AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_copy && !(wr_en && port_sel && second_phase)) |=> $stable(cur_addr)); // R6

  AST_RESET_ZERO: assert property (@(posedge clk)
    !rst_n |-> (cur_addr == '0 && fine_x == '0 && !second_phase)); // R9
endmodule

bind scroll_addr_unit sa_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .port_sel     (port_sel),
  .wr_data      (wr_data),
  .status_rd    (status_rd),
  .frame_copy   (frame_copy),
  .cur_addr     (cur_addr),
  .fine_x       (fine_x),
  .second_phase (second_phase)
);

// File: tb/sim_scroll_addr_unit.sv
`timescale 1ns/1ps
module sim_scroll_addr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        port_sel = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        status_rd = 1'b0;
  logic        frame_copy = 1'b0;
  logic [14:0] cur_addr;
  logic [2:0]  fine_x;
  logic        second_phase;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  int m_t = 0, m_v = 0, m_x = 0, m_w = 0;

  always #2.5 clk = ~clk;

  scroll_addr_unit u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .port_sel(port_sel),
    .wr_data(wr_data), .status_rd(status_rd), .frame_copy(frame_copy),
    .cur_addr(cur_addr), .fine_x(fine_x), .second_phase(second_phase)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmp_all(input string req);
    chk({req, " cur_addr"}, int'(cur_addr), m_v);
    chk({req, " fine_x"},   int'(fine_x),   m_x);
    chk({req, " phase"},    int'(second_phase), m_w);
  endtask

  // one clock: drive, advance model on the edge, sample 1 ns after
  task automatic step(input bit we, input bit ps, input int d,
                      input bit sr, input bit fc, input string req);
    wr_en = we; port_sel = ps; wr_data = d[7:0];
    status_rd = sr; frame_copy = fc;
    @(posedge clk);
    if (we) begin
      if (!ps) begin
        if (m_w == 0) begin m_t = (m_t & ~32'h1F) | ((d >> 3) & 31); m_x = d & 7; end
        else m_t = (m_t & ~32'h73E0) | (((d >> 3) & 31) << 5) | ((d & 7) << 12);
      end else begin
        if (m_w == 0) m_t = (m_t & 32'hFF) | ((d & 32'h3F) << 8);
        else begin m_t = (m_t & 32'h7F00) | (d & 32'hFF); m_v = m_t; end
      end
    end
    if (fc) m_v = m_t;
    if (sr) m_w = 0; else if (we) m_w = 1 - m_w;
    #1;
    wr_en = 0; status_rd = 0; frame_copy = 0;
    cmp_all(req);
  endtask

  task automatic split(input int nt, input int y, input int x);
    int exp_a;
    step(1, 1, nt << 2, 0, 0, "R4");
    step(1, 0, y, 0, 0, "R3");
    step(1, 0, x, 0, 0, "R2");
    step(1, 1, (((y >> 3) & 7) << 5) | (x >> 3), 0, 0, "R5");
    exp_a = ((y & 7) << 12) | ((nt & 3) << 10) | (((y >> 3) & 31) << 5) | ((x >> 3) & 31);
    chk("R10 split cur_addr", int'(cur_addr), exp_a);
    chk("R10 split fine_x", int'(fine_x), x & 7);
    chk("R10 split phase", int'(second_phase), 0);
  endtask

  initial begin
    #1;
    chk("R9 reset cur_addr", int'(cur_addr), 0);
    chk("R9 reset fine_x", int'(fine_x), 0);
    chk("R9 reset phase", int'(second_phase), 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step(0, 0, 0, 0, 0, "R9 idle");

    // R1 shared flag toggles across ports
    step(1, 0, 8'h00, 0, 0, "R1");
    step(1, 1, 8'h00, 0, 0, "R1");
    // scroll writes alone do not move live address (R6), frame copy does (R8)
    step(1, 0, 8'hAD, 0, 0, "R6 scroll X");
    step(1, 0, 8'h5E, 0, 0, "R6 scroll Y");
    chk("R6 live untouched", int'(cur_addr), 0);
    step(0, 0, 0, 0, 1, "R8 frame copy");
    chk("R8 copied", int'(cur_addr), 16'h6175 & 16'h7FFF);
    // R4 clears bit 14 and first address write does not commit
    step(1, 1, 8'hFF, 0, 0, "R4 first addr");
    chk("R6 after first addr", int'(cur_addr), m_v);
    step(1, 1, 8'h12, 0, 0, "R5 second addr");
    chk("R4 bit14 cleared", int'(cur_addr) >> 14, 0);
    // R7 status read clears flag, priority over write flip
    step(1, 1, 8'h3F, 0, 0, "R7 setup");
    step(0, 0, 0, 1, 0, "R7 status");
    chk("R7 phase cleared", int'(second_phase), 0);
    step(1, 1, 8'h15, 1, 0, "R7 write+status");
    chk("R7 priority", int'(second_phase), 0);
    // R8 copy concurrent with write includes the write
    step(1, 0, 8'hF8, 0, 1, "R8 copy with write");
    chk("R8 includes write", int'(cur_addr) & 31, 31);
    step(0, 0, 0, 1, 0, "R7 realign");

    split(0, 8'h00, 8'h00);
    split(1, 8'h47, 8'h9B);
    split(2, 8'hEF, 8'h03);
    split(3, 8'hFF, 8'hFF);
    split(2, 8'h38, 8'h7C);

    for (int i = 0; i < 200; i++) begin
      int r = $urandom;
      step(r[0], r[1], (r >> 8) & 255, (r[6:2] == 0), (r[11:7] == 0), "R1 mixed");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule